// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps a multiplexed-address DRAM alive for the memory controller around it. After reset it holds every strobe inactive for a start-up pause. It then asks an access arbiter for the bus several times and runs a fixed number of CAS-before-RAS (CBR) refresh cycles. When the last of those completes it raises an init-done flag, and normal traffic may begin.

From then on an interval timer marks one refresh as owed every refresh interval. The interval is the retention period divided by the number of rows. Owed refreshes collect in a small saturating counter, so the arbiter may finish a page burst before it hands the bus over. While anything is owed the block requests the bus. When the counter is full the block also raises an urgent flag that the arbiter must not ignore.

Once granted, the block drives one complete CBR cycle on its own:

1. CAS low while RAS is still high.
2. RAS low with CAS still low.
3. Both strobes high for the precharge time.

Write-enable and output-enable stay inactive throughout, and the data bus is never driven. No address is produced, because the device steps its own row counter on each CBR cycle. All durations are given in nanoseconds and turned into clock cycles from a clock-period parameter.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `ras_n`, every `cas_n` lane, `we_n` and `oe_n` are 1, and `dq_drive`, `ref_req`, `ref_urgent` and `init_done` are 0.
- R2: For the first PAUSE_C = ceil(PAUSE_NS/CLK_NS) clock edges after reset release, `ref_req` stays 0 and no strobe falls. `ref_req` is 1 by edge PAUSE_C+2.
- R3: After the pause, exactly INIT_N (default 8) CBR cycles run. `init_done` is still 0 when RAS rises at the end of the last of them, is 1 within N_RP+3 cycles of that rise, and then stays 1. No further cycle starts until a refresh is owed.
- R4: Each refresh cycle has a fixed shape. First, all `cas_n` lanes fall together exactly N_CSR cycles before `ras_n` falls. Next, `ras_n` stays low for exactly N_RAS cycles with CAS low throughout. Then both strobes rise on the same edge. Finally, both stay high for at least N_RP cycles before CAS falls again.
- R5: `we_n` and `oe_n` are 1 and `dq_drive` is 0 in every cycle.
- R6: A cycle started by a grant runs to completion even if the grant is held for only one cycle. A grant given while `ref_req` is 0 starts nothing.
- R7: After init, if the grant is held high continuously, successive RAS falls are exactly REFI_C = floor(REFI_NS/CLK_NS) cycles apart.
- R8: While the grant is withheld, one refresh is owed per interval. When the grant returns, exactly the owed number of cycles runs back to back and `ref_req` then drops to 0.
- R9: The owed count saturates at BACKLOG_MAX (default 8). `ref_urgent` rises within REFI_C cycles after the BACKLOG_MAX-th withheld interval and stays high while the count is full. A burst after saturation runs exactly BACKLOG_MAX cycles and leaves `ref_urgent` at 0.
- R10: `ref_req` is 0 in the cycle after a grant is accepted and stays 0 while that cycle runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst | input | 1 | Synchronous active-high reset |
| ref_grant | input | 1 | Arbiter grants the DRAM bus to the refresher |
| ref_req | output | 1 | A refresh or init cycle is wanted |
| ref_urgent | output | 1 | Owed count is full; refresh must not be postponed |
| init_done | output | 1 | Power-up pause and init cycles are finished |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | CAS_LANES | Column strobes (byte lanes), active low |
| we_n | output | 1 | Write enable, held inactive |
| oe_n | output | 1 | Output enable, held inactive |
| dq_drive | output | 1 | Data-bus drive enable, held at 0 |

## Verification
The design pipeline is fixed, so every result falls due at a known cycle:
- A pacing tick makes a request two edges later.
- An accepted grant pulls CAS low on the next edge and RAS low N_CSR edges after that.
- The pause ends PAUSE_C+1 edges after reset release.

The bench changes inputs and samples outputs on the falling clock edge and counts those edges. Strobe shapes are measured edge by edge by a monitor, and so are exact. Checks that depend on where a window falls in the tick phase are given a bounded window. Burst counts are taken at points the bench places between ticks, so that no tick can land in the measured span.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_CSR,
    ST_RASLO,
    ST_PRECH
  } rf_state_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns_to_cyc_up(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_pace_timer.sv
module rfsh_pace_timer #(
  parameter int PERIOD = 1950
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(PERIOD + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= CW'(PERIOD - 1);
      tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= CW'(PERIOD - 1);
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
      tick <= 1'b0;
    end
  end

  generate
    if (PERIOD > 1) begin : g_gap_chk
      // ticks are single-cycle pulses spaced by the interval
      assert_tick_gap_R7: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/rfsh_owed_ctr.sv
module rfsh_owed_ctr #(
  parameter int MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic owed_nz,
  output logic full
);
  localparam int OW = $clog2(MAX_OWED + 1);

  logic [OW-1:0] cnt, cnt_nx;

  always_comb begin
    cnt_nx = cnt;
    if (inc && dec)                            cnt_nx = cnt;
    else if (inc && (cnt != OW'(MAX_OWED)))    cnt_nx = cnt + 1'b1;
    else if (dec && (cnt != '0))               cnt_nx = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      full <= 1'b0;
    end else begin
      cnt  <= cnt_nx;
      full <= (cnt_nx == OW'(MAX_OWED));
    end
  end

  assign owed_nz = (cnt != '0);

  // a tick into a full counter with nothing retired keeps it full
  assert_saturate_R9: assert property (@(posedge clk) disable iff (rst)
    (cnt == OW'(MAX_OWED) && inc && !dec) |=> (cnt == OW'(MAX_OWED)));

  assert_urgent_full_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> (cnt == OW'(MAX_OWED)));

endmodule

// File: rtl/rfsh_cbr_seq.sv
module rfsh_cbr_seq
  import dram_rfsh_pkg::*;
#(
  parameter int PAUSE_C   = 25000,
  parameter int N_CSR     = 2,
  parameter int N_RAS     = 7,
  parameter int N_RP      = 4,
  parameter int INIT_N    = 8,
  parameter int CAS_LANES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 grant,
  input  logic                 owed_nz,
  output logic                 init_done,
  output logic                 req,
  output logic                 cyc_done,
  output logic                 ras_n,
  output logic [CAS_LANES-1:0] cas_n
);
  localparam int TMAX = imax(imax(PAUSE_C, N_CSR), imax(N_RAS, N_RP));
  localparam int TW   = $clog2(TMAX + 1);
  localparam int IW   = $clog2(INIT_N + 1);

  rf_state_e      st, st_nx;
  logic [TW-1:0]  tmr, tmr_nx;
  logic [IW-1:0]  init_cnt;
  logic           start, pending;

  assign pending  = init_done ? owed_nz : (init_cnt < IW'(INIT_N));
  assign start    = (st == ST_IDLE) && req && grant;
  assign cyc_done = (st == ST_PRECH) && (tmr == '0);

  always_comb begin
    st_nx  = st;
    tmr_nx = (tmr == '0) ? '0 : tmr - 1'b1;
    unique case (st)
      ST_PAUSE: if (tmr == '0) st_nx = ST_IDLE;
      ST_IDLE:  if (start) begin
                  st_nx  = ST_CSR;
                  tmr_nx = TW'(N_CSR - 1);
                end
      ST_CSR:   if (tmr == '0) begin
                  st_nx  = ST_RASLO;
                  tmr_nx = TW'(N_RAS - 1);
                end
      ST_RASLO: if (tmr == '0) begin
                  st_nx  = ST_PRECH;
                  tmr_nx = TW'(N_RP - 1);
                end
      ST_PRECH: if (tmr == '0) st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_PAUSE;
      tmr       <= TW'(PAUSE_C - 1);
      init_cnt  <= '0;
      init_done <= 1'b0;
      req       <= 1'b0;
      ras_n     <= 1'b1;
      cas_n     <= '1;
    end else begin
      st    <= st_nx;
      tmr   <= tmr_nx;
      req   <= (st == ST_IDLE) && !start && pending;
      ras_n <= !(st_nx == ST_RASLO);
      cas_n <= {CAS_LANES{!((st_nx == ST_CSR) || (st_nx == ST_RASLO))}};
      if (cyc_done && (init_cnt < IW'(INIT_N)))
        init_cnt <= init_cnt + 1'b1;
      init_done <= (init_cnt == IW'(INIT_N));
    end
  end

  assert_quiet_pause_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PAUSE) |-> (!req && ras_n && (cas_n == '1)));

  assert_cas_leads_ras_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> ($past(cas_n) == '0));

  assert_cas_held_R4: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> (cas_n == '0));

  assert_init_count_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> (init_cnt == IW'(INIT_N)));

  assert_req_drop_R10: assert property (@(posedge clk) disable iff (rst)
    start |=> !req);

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import dram_rfsh_pkg::*;
#(
  parameter int CLK_NS      = 8,
  parameter int PAUSE_NS    = 200000,
  parameter int REFI_NS     = 15600,
  parameter int TCSR_NS     = 10,
  parameter int TCHR_NS     = 10,
  parameter int TRAS_NS     = 50,
  parameter int TRP_NS      = 30,
  parameter int TRPC_NS     = 5,
  parameter int INIT_N      = 8,
  parameter int BACKLOG_MAX = 8,
  parameter int CAS_LANES   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ref_grant,
  output logic                 ref_req,
  output logic                 ref_urgent,
  output logic                 init_done,
  output logic                 ras_n,
  output logic [CAS_LANES-1:0] cas_n,
  output logic                 we_n,
  output logic                 oe_n,
  output logic                 dq_drive
);
  localparam int PAUSE_C = ns_to_cyc_up(PAUSE_NS, CLK_NS);
  localparam int REFI_C  = (REFI_NS / CLK_NS < 1) ? 1 : REFI_NS / CLK_NS;
  localparam int N_CSR   = ns_to_cyc_up(TCSR_NS, CLK_NS);
  localparam int N_RAS   = imax(ns_to_cyc_up(TRAS_NS, CLK_NS), ns_to_cyc_up(TCHR_NS, CLK_NS));
  localparam int N_RP    = imax(ns_to_cyc_up(TRP_NS, CLK_NS), ns_to_cyc_up(TRPC_NS, CLK_NS));

  logic tick, owed_nz, cyc_done;

  rfsh_pace_timer #(.PERIOD(REFI_C)) u_timer (
    .clk (clk),
    .rst (rst),
    .en  (init_done),
    .tick(tick)
  );

  rfsh_owed_ctr #(.MAX_OWED(BACKLOG_MAX)) u_owed (
    .clk    (clk),
    .rst    (rst),
    .inc    (tick),
    .dec    (cyc_done && init_done),
    .owed_nz(owed_nz),
    .full   (ref_urgent)
  );

  rfsh_cbr_seq #(
    .PAUSE_C  (PAUSE_C),
    .N_CSR    (N_CSR),
    .N_RAS    (N_RAS),
    .N_RP     (N_RP),
    .INIT_N   (INIT_N),
    .CAS_LANES(CAS_LANES)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .grant    (ref_grant),
    .owed_nz  (owed_nz),
    .init_done(init_done),
    .req      (ref_req),
    .cyc_done (cyc_done),
    .ras_n    (ras_n),
    .cas_n    (cas_n)
  );

  // refresh never reads or writes: keep the data path quiet
  assign we_n     = 1'b1;
  assign oe_n     = 1'b1;
  assign dq_drive = 1'b0;

endmodule

// File: tb/dram_refresh_ctrl_tb.sv
module dram_refresh_ctrl_tb;
  localparam int CLK_NS   = 8;
  localparam int PAUSE_NS = 400;
  localparam int REFI_NS  = 2000;
  localparam int LANES    = 2;
  localparam int PAUSE_C  = (PAUSE_NS + CLK_NS - 1) / CLK_NS;
  localparam int REFI_C   = REFI_NS / CLK_NS;
  localparam int N_CSR    = (10 + CLK_NS - 1) / CLK_NS;
  localparam int N_RAS    = (50 + CLK_NS - 1) / CLK_NS;
  localparam int N_RP     = (30 + CLK_NS - 1) / CLK_NS;
  localparam int INIT_N   = 8;
  localparam int BMAX     = 8;

  logic clk = 1'b0, rst = 1'b1, grant = 1'b0;
  logic req, urgent, idone, ras_n, we_n, oe_n, dq_drive;
  logic [LANES-1:0] cas_n;

  int checks = 0, errors = 0, cyc = 0, ras_falls = 0;
  int last_fall = 0, prev_fall = 0, cas_pre = 0, ras_len = 0, hi_len = 100;
  int quiet_bad = 0;
  logic prev_ras = 1'b1, prev_cas = 1'b1, idone_at_rise = 1'b0;

  always #4 clk = ~clk;

  dram_refresh_ctrl #(.CLK_NS(CLK_NS), .PAUSE_NS(PAUSE_NS), .REFI_NS(REFI_NS),
                      .INIT_N(INIT_N), .BACKLOG_MAX(BMAX), .CAS_LANES(LANES)) u_dut (
    .clk(clk), .rst(rst), .ref_grant(grant), .ref_req(req), .ref_urgent(urgent),
    .init_done(idone), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .dq_drive(dq_drive));

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req_tag, act, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_falls(input int target, input int limit);
    int k = 0;
    while (ras_falls < target && k < limit) begin
      @(negedge clk);
      k++;
    end
    chk(ras_falls >= target, "R7 wait", ras_falls, target);
  endtask

  // strobe-shape monitor, sampled on the falling edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (!rst) begin
      if (!(we_n && oe_n && !dq_drive)) quiet_bad++;
      if (cas_n != {LANES{cas_n[0]}}) quiet_bad++;
      if (prev_cas && !cas_n[0] && ras_n) begin
        chk(hi_len >= N_RP, "R4 precharge", hi_len, N_RP);
        cas_pre = 1;
      end else if (!cas_n[0] && ras_n) cas_pre++;
      if (prev_ras && !ras_n) begin
        ras_falls++;
        prev_fall = last_fall;
        last_fall = cyc;
        chk(cas_pre == N_CSR && cas_n[0] == 1'b0, "R4 cas lead", cas_pre, N_CSR);
        ras_len = 1;
      end else if (!ras_n) begin
        ras_len++;
        if (cas_n[0]) quiet_bad++;
      end
      if (!prev_ras && ras_n) begin
        chk(ras_len == N_RAS && cas_n[0], "R4 ras width", ras_len, N_RAS);
        idone_at_rise = idone;
        hi_len = 1;
      end else if (ras_n && cas_n[0]) hi_len++;
      prev_ras = ras_n;
      prev_cas = cas_n[0];
    end
  end

  initial begin
    int base, e, k;
    // R1 reset state
    step(3);
    chk(ras_n && cas_n == '1 && we_n && oe_n && !dq_drive && !req && !urgent && !idone,
        "R1 reset", {ras_n, req, urgent, idone}, 4'b1000);
    rst = 1'b0;
    step(1);
    chk(ras_n && !req && !idone, "R1 after release", req, 0);
    // R2 start-up pause
    step(PAUSE_C - 1);
    chk(!req && ras_falls == 0 && cas_n == '1, "R2 pause quiet", req, 0);
    step(2);
    chk(req == 1'b1, "R2 request after pause", req, 1);
    // R3 init cycles with single-cycle grants (R6 completion)
    for (int i = 0; i < INIT_N; i++) begin
      k = 0;
      while (!req && k < 200) begin
        step(1);
        k++;
      end
      grant = 1'b1;
      step(1);
      grant = 1'b0;
      step(1);
      chk(!req, "R10 req drops", req, 0);
    end
    step(N_RAS + N_CSR + 1);
    chk(idone_at_rise == 1'b0, "R3 flag late enough", idone_at_rise, 0);
    step(N_RP + 3);
    chk(idone == 1'b1, "R3 init_done", idone, 1);
    chk(ras_falls == INIT_N, "R3 init count", ras_falls, INIT_N);
    step(20);
    chk(ras_falls == INIT_N && !req, "R3 no extra cycle", ras_falls, INIT_N);
    // R6 grant without request
    grant = 1'b1;
    step(30);
    chk(ras_falls == INIT_N, "R6 idle grant", ras_falls, INIT_N);
    // R7 pacing under continuous grant
    wait_falls(INIT_N + 1, 2 * REFI_C);
    wait_falls(INIT_N + 2, 2 * REFI_C);
    chk(last_fall - prev_fall == REFI_C, "R7 spacing", last_fall - prev_fall, REFI_C);
    wait_falls(INIT_N + 3, 2 * REFI_C);
    chk(last_fall - prev_fall == REFI_C, "R7 spacing", last_fall - prev_fall, REFI_C);
    chk(idone == 1'b1, "R3 init_done held", idone, 1);
    // R9 saturation
    step(20);
    grant = 1'b0;
    k = 0;
    while (!urgent && k < 10 * REFI_C) begin
      step(1);
      k++;
    end
    e = cyc - last_fall;
    chk(e >= 8 * REFI_C - 6 && e <= 8 * REFI_C, "R9 urgent timing", e, 8 * REFI_C - 4);
    chk(req == 1'b1, "R8 request pending", req, 1);
    step(4 * REFI_C + 10);
    chk(urgent == 1'b1, "R9 urgent held", urgent, 1);
    base = ras_falls;
    grant = 1'b1;
    step(150);
    chk(ras_falls - base == BMAX, "R9 saturated burst", ras_falls - base, BMAX);
    chk(!req && !urgent, "R9 drained", {req, urgent}, 0);
    // R8 partial backlog
    grant = 1'b0;
    step(3 * REFI_C - 100);
    chk(req && !urgent, "R8 owed not full", {req, urgent}, 2);
    base = ras_falls;
    grant = 1'b1;
    step(120);
    chk(ras_falls - base == 3, "R8 burst count", ras_falls - base, 3);
    chk(!req, "R8 request cleared", req, 0);
    // R5 quiet data path over the whole run
    chk(quiet_bad == 0, "R5 we/oe/dq quiet", quiet_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule